// File: doc/BRIEF.md
# Binarized Depthwise Separable Convolution Unit

This unit computes one output position of a binary depthwise separable convolution layer. Each invocation takes a binary patch of three channels, each a 3x3 window. Every channel is masked by its own 3x3 binary depthwise kernel, and the surviving ones are counted. This is a two-input AND per tap followed by a population count, so each channel yields a count from 0 to 9.

Eighteen pointwise kernels, each holding one bit per channel, then select which of the three counts enter their sum. Each sum is compared against a signed integer threshold stored for its output channel. The threshold has batch normalization folded into it, so the comparison also serves as the activation. The result is an 18-bit binary feature vector in {0,1} encoding.

Weights and thresholds are written through a simple address/data/write-enable port. They keep their values across invocations. A start strobe launches a computation, and a one-cycle done pulse announces the result.

Top module: `bdsc_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first result, `done` is 0 and `feat_out` is all zeros. All weights and thresholds reset to 0.
- R2: When `start` is sampled high at a rising edge, `done` is high for exactly one cycle, after the second rising edge counted from and including that one. Back-to-back starts give back-to-back done cycles. `done` is never high otherwise.
- R3: The depthwise count of channel c is the number of taps t (0..8) for which both `patch_in[9*c+t]` and bit t of channel c's depthwise kernel are 1.
- R4: The sum for output channel o is the total of the depthwise counts of those channels c whose pointwise bit c for output o is 1.
- R5: Bit o of `feat_out` is 1 exactly when the sum for output o is strictly greater than threshold o, read as an 8-bit two's-complement value. Equality gives 0.
- R6: `feat_out` changes only in the cycle `done` is high and holds its value otherwise.
- R7: A write with `cfg_we` high stores data at the rising edge, mapped by `cfg_addr`. Addresses 0..2 take depthwise kernel c in `cfg_wdata[8:0]`, with bit t as tap t. Addresses 3..20 take pointwise weights of output (addr-3) in `cfg_wdata[2:0]`, with bit c as channel c. Addresses 21..38 take threshold (addr-21) in `cfg_wdata[7:0]`.
- R8: A write to any address from 39 to 63 changes no weight and no threshold.
- R9: The largest sum, 27 (all kernels and pointwise bits set, all-ones patch), is represented without wrap. Threshold 26 gives 1 and threshold 27 gives 0.
- R10: A negative threshold gives 1 even for an all-zero sum. A threshold of 0 with a zero sum gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Weight/threshold write enable |
| cfg_addr | input | 6 | Write address |
| cfg_wdata | input | 9 | Write data |
| start | input | 1 | Launches one computation on `patch_in` |
| patch_in | input | 27 | Binary patch, channel c taps at bits 9c..9c+8 |
| done | output | 1 | One-cycle result-valid pulse |
| feat_out | output | 18 | Binary output feature vector |

## Verification
The bench builds the unit with its default parameters: three channels of nine taps, eighteen outputs and 8-bit thresholds. These values make every address of the 6-bit write space reachable, including the unused range above 38. They also bring the sum to its full range of 0 to 27, so the saturation corner of R9 and the sign corner of R10 can be reached directly. Random weight sets, random patches and back-to-back starts are compared against a behavioural model on every clock.

// File: rtl/bdsc_unit.sv
module bdsc_unit #(
  parameter int NCH   = 3,
  parameter int KTAPS = 9,
  parameter int NOUT  = 18,
  parameter int TW    = 8,
  localparam int NADDR = NCH + 2 * NOUT,
  localparam int ADW   = $clog2(NADDR),
  localparam int WD    = (TW > KTAPS) ? TW : KTAPS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ADW-1:0]         cfg_addr,
  input  logic [WD-1:0]          cfg_wdata,
  input  logic                   start,
  input  logic [NCH*KTAPS-1:0]   patch_in,
  output logic                   done,
  output logic [NOUT-1:0]        feat_out
);
  localparam int CW   = $clog2(KTAPS + 1);
  localparam int SW   = $clog2(NCH * KTAPS + 1) + 1;
  localparam int CMPW = ((SW > TW) ? SW : TW) + 1;
  localparam int PW_BASE  = NCH;
  localparam int THR_BASE = NCH + NOUT;

  logic [KTAPS-1:0]     dw_k  [NCH];
  logic [NCH-1:0]       pw_k  [NOUT];
  logic signed [TW-1:0] thr_k [NOUT];

  logic [CW-1:0] cnt_d [NCH];
  logic [CW-1:0] cnt_q [NCH];
  logic          stage_v;
  logic [SW-1:0] sum_d [NOUT];
  logic [NOUT-1:0] hit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) dw_k[c] <= '0;
      for (int o = 0; o < NOUT; o++) begin
        pw_k[o]  <= '0;
        thr_k[o] <= '0;
      end
    end else if (cfg_we) begin
      for (int c = 0; c < NCH; c++)
        if (cfg_addr == ADW'(c)) dw_k[c] <= cfg_wdata[KTAPS-1:0];
      for (int o = 0; o < NOUT; o++) begin
        if (cfg_addr == ADW'(PW_BASE + o))  pw_k[o]  <= cfg_wdata[NCH-1:0];
        if (cfg_addr == ADW'(THR_BASE + o)) thr_k[o] <= cfg_wdata[TW-1:0];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cnt_d[c] = '0;
      for (int t = 0; t < KTAPS; t++)
        cnt_d[c] = cnt_d[c] + CW'(patch_in[c*KTAPS + t] & dw_k[c][t]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_v <= 1'b0;
      for (int c = 0; c < NCH; c++) cnt_q[c] <= '0;
    end else begin
      stage_v <= start;
      if (start)
        for (int c = 0; c < NCH; c++) cnt_q[c] <= cnt_d[c];
    end
  end

  always_comb begin
    for (int o = 0; o < NOUT; o++) begin
      sum_d[o] = '0;
      for (int c = 0; c < NCH; c++)
        if (pw_k[o][c]) sum_d[o] = sum_d[o] + SW'(cnt_q[c]);
      hit_d[o] = $signed({{(CMPW-SW){1'b0}}, sum_d[o]}) >
                 $signed({{(CMPW-TW){thr_k[o][TW-1]}}, thr_k[o]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      feat_out <= '0;
    end else begin
      done <= stage_v;
      if (stage_v) feat_out <= hit_d;
    end
  end
endmodule

module bdsc_unit_chk #(
  parameter int NOUT = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            done,
  input logic [NOUT-1:0] feat_out
);
  // R2
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));

  // R2
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start, 2) && $past(rst_n, 2) && $past(rst_n)) |-> done);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(start)) |=> !done);

  // R6
  feat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(feat_out));
endmodule

bind bdsc_unit bdsc_unit_chk #(.NOUT(NOUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .feat_out(feat_out)
);

// File: tb/bdsc_unit_tb.sv
module bdsc_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int NCH = 3, KTAPS = 9, NOUT = 18;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [5:0] cfg_addr = '0;
  logic [8:0] cfg_wdata = '0;
  logic start = 0;
  logic [26:0] patch_in = '0;
  logic done;
  logic [17:0] feat_out;

  bdsc_unit dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
                   .cfg_wdata(cfg_wdata), .start(start), .patch_in(patch_in),
                   .done(done), .feat_out(feat_out));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  int sh_dw [NCH];
  int sh_pw [NOUT];
  int sh_thr [NOUT];

  typedef struct { int due; logic [17:0] vec; } pend_t;
  pend_t q [$];
  int cyc = 0;
  logic exp_done = 0;
  logic [17:0] exp_feat = '0;

  function automatic logic [17:0] ref_vec(logic [26:0] p);
    logic [17:0] r;
    for (int o = 0; o < NOUT; o++) begin
      int s = 0;
      for (int c = 0; c < NCH; c++) begin
        int n = 0;
        for (int t = 0; t < KTAPS; t++)
          if (p[9*c+t] && sh_dw[c][t]) n++;
        if (sh_pw[o][c]) s += n;
      end
      r[o] = (s > sh_thr[o]);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_n && start) begin
      pend_t e;
      e.due = cyc + 1;
      e.vec = ref_vec(patch_in);
      q.push_back(e);
    end
  end

  // R2 R6: compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      exp_done = 0;
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_done = 1;
        exp_feat = q[0].vec;
        void'(q.pop_front());
      end
      n_chk++;
      if (done !== exp_done || feat_out !== exp_feat) begin
        n_bad++;
        $display("FAIL %s cyc=%0d done=%0b exp=%0b feat=%h exp=%h",
                 cur_req, cyc, done, exp_done, feat_out, exp_feat);
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = 9'(d);
    // R7 map, R8 unused range
    if (a < 3) sh_dw[a] = d & 'h1ff;
    else if (a < 21) sh_pw[a-3] = d & 7;
    else if (a < 39) sh_thr[a-21] = int'($signed(8'(d)));
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(logic [26:0] p);
    @(negedge clk);
    start = 1; patch_in = p;
    @(negedge clk);
    start = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(int dwv, int pwv, int thv);
    for (int c = 0; c < NCH; c++) wr(c, dwv);
    for (int o = 0; o < NOUT; o++) wr(3 + o, pwv);
    for (int o = 0; o < NOUT; o++) wr(21 + o, thv);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) sh_dw[c] = 0;
    for (int o = 0; o < NOUT; o++) begin sh_pw[o] = 0; sh_thr[o] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (done !== 0 || feat_out !== '0) begin
      n_bad++;
      $display("FAIL R1 done=%0b exp=0 feat=%h exp=0", done, feat_out);
    end
    rst_n = 1;
    idle(2);
    cur_req = "R1";
    run(27'h7ffffff);   // all weights 0, thresholds 0 -> zeros
    idle(3);

    // R7 R3 R4 R5: distinct per-channel kernels, pointwise sets, thresholds
    cur_req = "R3/R4/R5/R7";
    wr(0, 'h1ff); wr(1, 'h0aa); wr(2, 'h00f);
    for (int o = 0; o < NOUT; o++) wr(3 + o, (o % 7) + 1);
    for (int o = 0; o < NOUT; o++) wr(21 + o, o);
    run(27'h7ffffff); idle(3);
    run(27'h0000000); idle(3);
    run(27'h5555555); idle(3);
    run({9'h0f0, 9'h033, 9'h1c7}); idle(3);

    // R2: back-to-back starts
    cur_req = "R2";
    @(negedge clk); start = 1; patch_in = 27'h12345ab;
    @(negedge clk); patch_in = 27'h7fff000;
    @(negedge clk); patch_in = 27'h00001ff;
    @(negedge clk); start = 0;
    idle(4);

    // R8: unused addresses ignored
    cur_req = "R8";
    for (int a = 39; a < 64; a++) wr(a, 'h1ff);
    run(27'h7ffffff); idle(3);
    run({9'h0f0, 9'h033, 9'h1c7}); idle(3);

    // R9: max sum 27, thresholds 26 and 27
    cur_req = "R9";
    fill('h1ff, 7, 26);
    for (int o = 9; o < NOUT; o++) wr(21 + o, 27);
    run(27'h7ffffff); idle(3);

    // R10: negative threshold vs zero threshold on zero sum
    cur_req = "R10";
    for (int o = 0; o < NOUT; o++) wr(21 + o, (o < 9) ? 'hff : 0);
    run(27'h0000000); idle(3);
    wr(21, 'h80);
    run(27'h0000000); idle(3);

    // R3 R4 R5 R6: random weight sets and patches
    cur_req = "R3/R4/R5/R6";
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < NCH; c++) wr(c, int'($urandom_range(0, 511)));
      for (int o = 0; o < NOUT; o++) wr(3 + o, int'($urandom_range(0, 7)));
      for (int o = 0; o < NOUT; o++) wr(21 + o, int'($urandom_range(0, 34)) - 4);
      for (int j = 0; j < 10; j++) begin
        run(27'($urandom));
        idle(int'($urandom_range(0, 3)));
      end
      idle(3);
    end

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog %s expired", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule